// File: doc/BRIEF.md
# Zero-Suppressed Multi-Channel Waveform Capture

This block takes eight parallel 12-bit sample streams, each delivering one sample per clock at 100 MSPS. When a trigger arrives it opens an acquisition window of a programmed length. During the window it keeps only the samples that lie above a threshold set for that channel. Each kept sample becomes one output word that carries the channel number, the sample's position within the window and its value. The words leave on a ready/valid stream that feeds a capture buffer.

Every accepted trigger yields exactly one block. A block is a header word carrying a running trigger count, then the data words in time order, then a trailer word. The trailer reports how many samples were kept and whether any were lost. Samples that cross the threshold in the same clock are queued together as one row. The row is then sent out one channel at a time. When the consumer stalls and the internal queue runs short, whole rows are discarded and the overflow flag is raised. Room is always kept for the trailer.

Top module: `zs_capture`

## Requirements
- R1: After reset `outValid` is low, and no word appears while no trigger has been accepted, whatever the samples and thresholds are.
- R2: A high `trigIn` sampled while no block is open and at least two queue slots are free starts a block. The header word has bits [30:29] = 2'b10 and the trigger count zero-extended in the low bits. The count is 0 for the first block after reset and rises by one per accepted trigger.
- R3: During the window, a channel's sample is exported only if its unsigned value is strictly greater than that channel's threshold. A sample equal to the threshold is dropped.
- R4: A data word has bits [30:29] = 2'b01, channel in [28:26], window index in [25:12] and sample value in [11:0]. Index 0 is the sample present in the clock after the trigger was sampled.
- R5: Data words come out in index order. Within one index they come out in ascending channel order.
- R6: `winLen` is read when the trigger is accepted. A value above MAX_WIN is treated as MAX_WIN. A value of 0 gives a block with a header and a trailer only. Samples after the window produce no words.
- R7: The trailer follows the block's last data word. It has bits [30:29] = 2'b11, the overflow flag at bit CNT_W and the count of exported samples in bits [CNT_W-1:0].
- R8: A trigger that arrives while a block is open is ignored. It produces no header and does not advance the trigger count.
- R9: A row with at least one hit is discarded whole when fewer than two queue slots are free. In that case the overflow flag of the block is set and the discarded samples are left out of the count. Headers and trailers are never discarded.
- R10: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | Trigger, sampled each clock |
| sampleBus | input | NUM_CH*SAMPLE_W | One sample per channel, channel c in bits [c*SAMPLE_W +: SAMPLE_W] |
| thresholdBus | input | NUM_CH*SAMPLE_W | Per-channel suppression thresholds, same packing |
| winLen | input | IDX_W | Window length in samples |
| outReady | input | 1 | Consumer ready |
| outValid | output | 1 | Output word valid |
| outData | output | 2+CH_W+IDX_W+SAMPLE_W | Header, data or trailer word |

## Verification
The bench builds the block with MAX_WIN = 40 and FIFO_DEPTH = 16. All other parameters stay at their defaults, so the word layout is the 31-bit format above. The short window limit lets one run drive a `winLen` above the limit and observe the clamp. The 16-entry queue fills within a 30-sample stalled window, which brings row discarding and the trailer's overflow flag within reach. Dense windows of at most 14 samples cannot lose rows at this depth. Sparse long windows drain as fast as they fill, so every block except the stalled one has an exact expected word list.

// File: rtl/zs_pkg.sv
package zs_pkg;
  typedef struct packed {
    logic pushHdr;
    logic pushRow;
    logic pushTrl;
  } zsStrobe_t;

  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_DATA = 2'b01,
    KIND_HDR  = 2'b10,
    KIND_TRL  = 2'b11
  } zsKind_t;
endpackage

// File: rtl/zs_ctrl.sv
module zs_ctrl
  import zs_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int IDX_W    = 14,
  parameter int MAX_WIN  = 10000,
  parameter int TRIG_W   = 16,
  parameter int CNT_W    = 17,
  parameter int FREE_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigIn,
  input  logic [IDX_W-1:0]  winLen,
  input  logic [NUM_CH-1:0] hitMask,
  input  logic [FREE_W-1:0] fifoFree,
  output zsStrobe_t         strobe,
  output logic [IDX_W-1:0]  sampIdx,
  output logic [TRIG_W-1:0] trigCnt,
  output logic [CNT_W-1:0]  sampCnt,
  output logic              ovfFlag
);
  typedef enum logic [1:0] {ST_IDLE, ST_CAPT, ST_TRAIL} ctrlState_t;

  localparam logic [IDX_W-1:0]  WIN_LIMIT = IDX_W'(MAX_WIN);
  localparam logic [FREE_W-1:0] MIN_FREE  = FREE_W'(2);

  ctrlState_t       state;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] effLen;
  logic             roomOk;

  assign effLen = (winLen > WIN_LIMIT) ? WIN_LIMIT : winLen;
  assign roomOk = (fifoFree >= MIN_FREE);

  always_comb begin
    strobe = '0;
    case (state)
      ST_IDLE:  strobe.pushHdr = trigIn && roomOk;
      ST_CAPT:  strobe.pushRow = (|hitMask) && roomOk;
      ST_TRAIL: strobe.pushTrl = 1'b1;
      default:  strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      lastIdx <= '0;
      sampIdx <= '0;
      trigCnt <= '0;
      sampCnt <= '0;
      ovfFlag <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strobe.pushHdr) begin
            trigCnt <= trigCnt + 1'b1;
            sampIdx <= '0;
            sampCnt <= '0;
            ovfFlag <= 1'b0;
            lastIdx <= effLen - 1'b1;
            state   <= (effLen == '0) ? ST_TRAIL : ST_CAPT;
          end
        end
        ST_CAPT: begin
          if (strobe.pushRow) begin
            sampCnt <= sampCnt + CNT_W'($countones(hitMask));
          end else if (|hitMask) begin
            ovfFlag <= 1'b1;
          end
          if (sampIdx == lastIdx) begin
            state <= ST_TRAIL;
          end else begin
            sampIdx <= sampIdx + 1'b1;
          end
        end
        ST_TRAIL: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/zs_datapath.sv
module zs_datapath
  import zs_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int SAMPLE_W   = 12,
  parameter int IDX_W      = 14,
  parameter int FIFO_DEPTH = 16,
  parameter int TRIG_W     = 16,
  parameter int CNT_W      = 17,
  parameter int CH_W       = 3,
  parameter int FREE_W     = 5,
  parameter int WORD_W     = 31
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  zsStrobe_t                  strobe,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleBus,
  input  logic [NUM_CH*SAMPLE_W-1:0] thresholdBus,
  input  logic [IDX_W-1:0]           sampIdx,
  input  logic [TRIG_W-1:0]          trigCnt,
  input  logic [CNT_W-1:0]           sampCnt,
  input  logic                       ovfFlag,
  input  logic                       outReady,
  output logic [NUM_CH-1:0]          hitMask,
  output logic [FREE_W-1:0]          fifoFree,
  output logic                       outValid,
  output logic [WORD_W-1:0]          outData
);
  localparam int VALS_W  = NUM_CH * SAMPLE_W;
  localparam int ENTRY_W = 2 + NUM_CH + VALS_W + IDX_W;
  localparam int PTR_W   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam logic [PTR_W-1:0]  LAST_PTR = PTR_W'(FIFO_DEPTH - 1);
  localparam logic [FREE_W-1:0] DEPTH_V  = FREE_W'(FIFO_DEPTH);

  // per-channel strict comparators
  for (genvar c = 0; c < NUM_CH; c++) begin : gCmp
    assign hitMask[c] = sampleBus[c*SAMPLE_W +: SAMPLE_W] > thresholdBus[c*SAMPLE_W +: SAMPLE_W];
  end

  // queue entry assembly
  zsKind_t           wrKind;
  logic [NUM_CH-1:0] wrMask;
  logic [VALS_W-1:0] wrVals;
  logic [IDX_W-1:0]  wrIdx;
  logic              push;

  assign push = strobe.pushHdr | strobe.pushRow | strobe.pushTrl;

  always_comb begin
    wrKind = KIND_NONE;
    wrMask = '0;
    wrVals = '0;
    wrIdx  = '0;
    if (strobe.pushHdr) begin
      wrKind = KIND_HDR;
      wrVals = VALS_W'(trigCnt);
    end else if (strobe.pushRow) begin
      wrKind = KIND_DATA;
      wrMask = hitMask;
      wrVals = sampleBus;
      wrIdx  = sampIdx;
    end else if (strobe.pushTrl) begin
      wrKind = KIND_TRL;
      wrVals = VALS_W'({ovfFlag, sampCnt});
    end
  end

  // row queue
  logic [ENTRY_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [FREE_W-1:0]  fillCnt;
  logic               pop;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= {wrKind, wrMask, wrVals, wrIdx};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fillCnt <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      fillCnt <= fillCnt + FREE_W'(push) - FREE_W'(pop);
    end
  end

  assign fifoFree = DEPTH_V - fillCnt;

  // head-of-queue serializer
  logic [ENTRY_W-1:0] head;
  zsKind_t            headKind;
  logic [NUM_CH-1:0]  headMask, doneMask, pendMask, selBit;
  logic [VALS_W-1:0]  headVals;
  logic [IDX_W-1:0]   headIdx;
  logic [CH_W-1:0]    selCh;
  logic               fire;

  assign head     = mem[rdPtr];
  assign headKind = zsKind_t'(head[ENTRY_W-1 -: 2]);
  assign headMask = head[ENTRY_W-3 -: NUM_CH];
  assign headVals = head[IDX_W +: VALS_W];
  assign headIdx  = head[IDX_W-1:0];
  assign pendMask = headMask & ~doneMask;

  always_comb begin
    selCh = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (pendMask[c]) selCh = CH_W'(c);
    end
  end

  assign selBit   = NUM_CH'(1) << selCh;
  assign outValid = (fillCnt != '0);
  assign fire     = outValid && outReady;
  assign pop      = fire && ((headKind != KIND_DATA) || ((pendMask & ~selBit) == '0));

  always_comb begin
    if (headKind == KIND_DATA) begin
      outData = {KIND_DATA, selCh, headIdx, headVals[selCh*SAMPLE_W +: SAMPLE_W]};
    end else begin
      outData = {headKind, headVals[WORD_W-3:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneMask <= '0;
    end else if (pop) begin
      doneMask <= '0;
    end else if (fire) begin
      doneMask <= doneMask | selBit;
    end
  end
endmodule

// File: rtl/zs_capture.sv
module zs_capture
  import zs_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int SAMPLE_W   = 12,
  parameter int IDX_W      = 14,
  parameter int MAX_WIN    = 10000,
  parameter int FIFO_DEPTH = 16,
  parameter int TRIG_W     = 16,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int CNT_W     = $clog2(MAX_WIN * NUM_CH + 1),
  localparam int FREE_W    = $clog2(FIFO_DEPTH + 1),
  localparam int WORD_W    = 2 + CH_W + IDX_W + SAMPLE_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       trigIn,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleBus,
  input  logic [NUM_CH*SAMPLE_W-1:0] thresholdBus,
  input  logic [IDX_W-1:0]           winLen,
  input  logic                       outReady,
  output logic                       outValid,
  output logic [WORD_W-1:0]          outData
);
  zsStrobe_t         strobe;
  logic [NUM_CH-1:0] hitMask;
  logic [FREE_W-1:0] fifoFree;
  logic [IDX_W-1:0]  sampIdx;
  logic [TRIG_W-1:0] trigCnt;
  logic [CNT_W-1:0]  sampCnt;
  logic              ovfFlag;

  zs_ctrl #(
    .NUM_CH(NUM_CH), .IDX_W(IDX_W), .MAX_WIN(MAX_WIN),
    .TRIG_W(TRIG_W), .CNT_W(CNT_W), .FREE_W(FREE_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .winLen(winLen),
    .hitMask(hitMask), .fifoFree(fifoFree), .strobe(strobe),
    .sampIdx(sampIdx), .trigCnt(trigCnt), .sampCnt(sampCnt), .ovfFlag(ovfFlag)
  );

  zs_datapath #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W), .FIFO_DEPTH(FIFO_DEPTH),
    .TRIG_W(TRIG_W), .CNT_W(CNT_W), .CH_W(CH_W), .FREE_W(FREE_W), .WORD_W(WORD_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleBus(sampleBus),
    .thresholdBus(thresholdBus), .sampIdx(sampIdx), .trigCnt(trigCnt),
    .sampCnt(sampCnt), .ovfFlag(ovfFlag), .outReady(outReady),
    .hitMask(hitMask), .fifoFree(fifoFree), .outValid(outValid), .outData(outData)
  );
endmodule

// File: rtl/zs_capture_checker.sv
module zs_capture_checker
  import zs_pkg::*;
#(
  parameter int IDX_W    = 14,
  parameter int SAMPLE_W = 12,
  parameter int MAX_WIN  = 10000,
  parameter int WORD_W   = 31
) (
  input logic              clk,
  input logic              rstN,
  input logic              outValid,
  input logic              outReady,
  input logic [WORD_W-1:0] outData,
  input zsStrobe_t         strobe
);
  logic openBlk;

  always_ff @(posedge clk) begin
    if (!rstN) openBlk <= 1'b0;
    else if (strobe.pushHdr) openBlk <= 1'b1;
    else if (strobe.pushTrl) openBlk <= 1'b0;
  end

  // R10: a stalled word stays put
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R4: every presented word carries a legal kind code
  a_r4_kind_legal: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outData[WORD_W-1 -: 2] != 2'b00));

  // R6: data indices stay inside the clamped window
  a_r6_idx_in_window: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outData[WORD_W-1 -: 2] == 2'b01) |-> (outData[SAMPLE_W +: IDX_W] < IDX_W'(MAX_WIN)));

  // R8: no header while a block is open
  a_r8_no_nested_header: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushHdr |-> !openBlk);

  // R7: a trailer only closes an open block
  a_r7_trailer_closes: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushTrl |-> openBlk);

  // R9: rows are queued only inside a block
  a_r9_row_in_block: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushRow |-> openBlk);
endmodule

bind zs_capture zs_capture_checker #(
  .IDX_W(IDX_W), .SAMPLE_W(SAMPLE_W), .MAX_WIN(MAX_WIN), .WORD_W(WORD_W)
) uChk (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outReady(outReady),
  .outData(outData), .strobe(strobe)
);

// File: tb/zs_capture_test.sv
module zs_capture_test;
  localparam int NCH = 8;
  localparam int SW  = 12;
  localparam int IW  = 14;
  localparam int MW  = 40;
  localparam int FD  = 16;
  localparam int WW  = 31;

  typedef struct packed {
    logic [13:0] len;
    logic [11:0] base;
    logic [11:0] step;
    logic [7:0]  seed;
    logic [1:0]  mode;
  } vec_t;

  // mode 0 dense mix, 1 sparse (one hit per index), 2 equal-then-above
  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{14'd10, 12'd2000, 12'd0,   8'd1, 2'd0},
    '{14'd12, 12'd0,    12'd0,   8'd2, 2'd0},
    '{14'd8,  12'd4095, 12'd0,   8'd3, 2'd0},
    '{14'd14, 12'd500,  12'd500, 8'd4, 2'd0},
    '{14'd1,  12'd1000, 12'd100, 8'd5, 2'd0},
    '{14'd0,  12'd100,  12'd0,   8'd6, 2'd0},
    '{14'd50, 12'd4000, 12'd0,   8'd7, 2'd1},
    '{14'd2,  12'd1000, 12'd7,   8'd8, 2'd2}
  };
  localparam string VTAG [NVEC] = '{"R3,R4,R5", "R3,R5", "R3", "R3,R4",
                                    "R4,R7", "R6", "R6", "R3"};

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              trigIn = 1'b0;
  logic [NCH*SW-1:0] sampleBus = '0;
  logic [NCH*SW-1:0] thresholdBus = '0;
  logic [IW-1:0]     winLen = '0;
  logic              outReady = 1'b1;
  logic              outValid;
  logic [WW-1:0]     outData;

  int checks = 0;
  int errors = 0;
  int trigExp = 0;
  string curTag = "R1";
  logic [WW-1:0] expQ [$];
  int thrA [NCH];

  always #5 clk = ~clk;

  zs_capture #(.MAX_WIN(MW), .FIFO_DEPTH(FD)) uut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .sampleBus(sampleBus),
    .thresholdBus(thresholdBus), .winLen(winLen), .outReady(outReady),
    .outValid(outValid), .outData(outData)
  );

  function automatic int genVal(int ch, int i, int seed, int mode, int thr);
    if (mode == 2) return (i == 0) ? thr : thr + 1;
    if (mode == 1) return (ch == i % 8) ? 4095 : (i*97 + ch*301 + seed*59) % 4000;
    return (i*97 + ch*301 + seed*59 + i*ch*13) % 4096;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, expv);
    end
  endtask

  // word monitor: compares every accepted word with the model queue
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, curTag, "unexpected word", outData, 0);
      end else begin
        logic [WW-1:0] e;
        e = expQ.pop_front();
        check(outData == e, curTag, "word", outData, e);
      end
    end
  end

  task automatic runBlock(int len, int base, int step, int seed, int mode,
                          bit stall, bit midTrig, string tag);
    int eff, cnt, rowsKept;
    bit ovf;
    logic [WW-1:0] held;
    curTag = tag;
    for (int c = 0; c < NCH; c++) begin
      thrA[c] = base + c*step;
      if (thrA[c] > 4095) thrA[c] = 4095;
      thresholdBus[c*SW +: SW] = SW'(thrA[c]);
    end
    winLen = IW'(len);
    eff = (len > MW) ? MW : len;
    cnt = 0; rowsKept = 0; ovf = 1'b0;
    expQ.push_back({2'b10, 29'(trigExp)});
    trigExp++;
    for (int i = 0; i < eff; i++) begin
      int hits;
      hits = 0;
      for (int c = 0; c < NCH; c++)
        if (genVal(c, i, seed, mode, thrA[c]) > thrA[c]) hits++;
      if (hits != 0) begin
        if (stall && rowsKept >= FD - 2) begin
          ovf = 1'b1;
        end else begin
          rowsKept++;
          for (int c = 0; c < NCH; c++) begin
            int v;
            v = genVal(c, i, seed, mode, thrA[c]);
            if (v > thrA[c]) begin
              expQ.push_back({2'b01, 3'(c), 14'(i), 12'(v)});
              cnt++;
            end
          end
        end
      end
    end
    expQ.push_back({2'b11, 19'd0, ovf, 9'(cnt)});
    outReady = !stall;
    @(negedge clk); trigIn = 1'b1;
    @(negedge clk); trigIn = 1'b0;
    for (int i = 0; i < len; i++) begin
      for (int c = 0; c < NCH; c++)
        sampleBus[c*SW +: SW] = SW'(genVal(c, i, seed, mode, thrA[c]));
      trigIn = (midTrig && i == 2);
      @(negedge clk);
    end
    trigIn = 1'b0;
    sampleBus = '0;
    if (stall) begin
      repeat (3) @(negedge clk);
      held = outData;
      repeat (4) @(negedge clk);
      check(outValid && outData == held, "R10", "stalled word held", outData, held);
      outReady = 1'b1;
    end
    for (int n = 0; n < 2000 && expQ.size() != 0; n++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0 && !outValid, tag, "block complete", expQ.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!outValid, "R1", "valid during reset", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid, "R1", "valid after reset", outValid, 0);
    // R1: no trigger, samples above thresholds, nothing may appear
    sampleBus = {NCH{12'hFFF}};
    thresholdBus = '0;
    repeat (20) @(negedge clk);
    check(!outValid, "R1", "word without trigger", outValid, 0);
    sampleBus = '0;

    for (int k = 0; k < NVEC; k++) begin
      runBlock(int'(VECS[k].len), int'(VECS[k].base), int'(VECS[k].step),
               int'(VECS[k].seed), int'(VECS[k].mode), 1'b0, 1'b0, VTAG[k]);
    end

    // R8: second trigger inside an open window leaves the block unchanged
    runBlock(20, 4000, 0, 9, 1, 1'b0, 1'b1, "R8");
    // R2: header count continues after the ignored trigger
    runBlock(3, 3000, 0, 10, 0, 1'b0, 1'b0, "R2");
    // R9: stalled consumer, dense window, rows beyond the reserve dropped
    runBlock(30, 0, 0, 11, 0, 1'b1, 1'b0, "R9");
    // R7: count and flag start fresh in the next block
    runBlock(5, 2500, 0, 12, 0, 1'b0, 1'b0, "R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule